// File: doc/BRIEF.md
# Output Undervoltage Fault Response Controller

This block sits in a power-stage controller and decides what happens to the power stage when the output undervoltage comparator trips. One configuration byte sets the policy. Its top two bits pick the action: run on and ignore the fault, shut down once the fault has lasted a number of PWM clock ticks, or shut down at once. The middle three bits set how many restarts may be tried. The low three bits set the shutdown delay, and they also scale the hiccup wait as a multiple of the soft-start rise time. After each shutdown the block waits one hiccup period and restarts. When the restarts it may try are used up, it latches the power stage off.

The byte arrives on a valid/ready write port. `cfg_ready` is always high, so a write is taken in every cycle in which `cfg_valid` is high and the port never applies back-pressure. A byte whose action field holds the unused code is refused. The refusal sets a sticky flag for the host. The stored byte can be read at any time on `cfg_rd_data`, and a newly accepted byte governs the sequencer from the next cycle on, even while the block is running.

`run_req` is the host's enable level. A high level is an enable command, and a low level is an OFF command. All timing counts `pwm_tick` pulses, and `rise_ticks` gives the soft-start rise time in those pulses.

Top module: `uv_fault_ctl`

## Requirements
- R1: After reset, `pwr_en`, `latched_off` and `cfg_invalid` are 0, and `cfg_rd_data` reads the parameter `RST_CFG`, which defaults to 8'h80.
- R2: When `run_req` is low at a clock edge, `pwr_en` is 0 in the following cycle, whatever the state, and the restart count is cleared. When `run_req` is high in the off state, `pwr_en` goes to 1 in the next cycle.
- R3: With action bits [7:6] = 00, an undervoltage has no effect and `pwr_en` stays 1.
- R4: With action bits [7:6] = 10, an undervoltage seen while `pwr_en` is 1 makes `pwr_en` 0 in the next cycle.
- R5: With action bits [7:6] = 01, the stage shuts down on the Nth `pwm_tick` that is counted while the undervoltage persists. N is 3 for delay bits [2:0] = 0 or 1, 5 for 2 to 4, and 9 for 5 to 7.
- R6: In delayed mode, if `uv_flag` drops before the count ends, no shutdown happens and the count starts again from zero on the next undervoltage.
- R7: A hiccup wait lasts M × `rise_ticks` pwm ticks, where M = 1 for delay code 0 or 1 and M equals the code otherwise. At the end of the wait `pwr_en` returns to 1 as a restart attempt.
- R8: With retry bits [5:3] = 0, a shutdown sets `latched_off` directly and no hiccup follows.
- R9: With retry bits [5:3] = 1 to 6, exactly that many restart attempts are made. The next shutdown after them latches off.
- R10: With retry bits [5:3] = 7, restart attempts continue without limit.
- R11: `startup_done` high while running with no undervoltage marks a successful start and clears the restart count.
- R12: A write with bits [7:6] = 11 is refused: `cfg_rd_data` is unchanged and `cfg_invalid` sets and stays set until `inv_clr` is pulsed.
- R13: `latched_off` is cleared only by a rising edge of `run_req` (which also restarts the stage) or by reset.
- R14: An accepted write is visible on `cfg_rd_data` in the next cycle and governs the fault response from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Enable level; low is an OFF command |
| uv_flag | input | 1 | Output undervoltage comparator result |
| pwm_tick | input | 1 | One-cycle pulse per PWM clock period |
| startup_done | input | 1 | Soft start has completed |
| rise_ticks | input | RISE_W | Soft-start rise time in pwm ticks |
| cfg_valid | input | 1 | Configuration byte offered |
| cfg_data | input | 8 | Configuration byte |
| cfg_ready | output | 1 | Always 1; writes are never stalled |
| cfg_rd_data | output | 8 | Stored configuration byte |
| inv_clr | input | 1 | Clears the invalid-data flag |
| pwr_en | output | 1 | Power stage enable |
| latched_off | output | 1 | Stage is latched off |
| cfg_invalid | output | 1 | Sticky flag for a refused write |

## Verification
The bench counts ticks at the edge of each delay band (codes 1, 4 and 7). A design with an off-by-one in the band table would shut down one tick early or one tick late. It drops the fault one tick short of the limit and then raises it again. A counter that is not cleared would then cut power on the first tick of the second fault. It runs a bounded retry policy to exhaustion, with a successful start placed between attempts. A counter that saturates wrongly, or that success does not reset, would latch off too early or never latch off. It also checks that a refused byte leaves the stored policy intact, that holding enable high does not release a latch-off, and that an OFF command in the middle of a hiccup ends the restart sequence.

// File: rtl/uvf_pkg.sv
package uvf_pkg;

  typedef enum logic [1:0] {
    RESP_IGNORE  = 2'b00,
    RESP_DELAYED = 2'b01,
    RESP_IMMED   = 2'b10,
    RESP_BAD     = 2'b11
  } resp_e;

  typedef struct packed {
    resp_e      resp;
    logic [2:0] retry;
    logic [2:0] dly;
  } uv_cfg_t;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RUN,
    ST_WAIT,
    ST_HICCUP,
    ST_LATCH
  } seq_st_e;

  localparam logic [2:0] RETRY_FOREVER = 3'd7;

  // shutdown delay in pwm ticks for a delay code
  function automatic logic [3:0] dly_ticks(input logic [2:0] code);
    if (code <= 3'd1)      return 4'd3;
    else if (code <= 3'd4) return 4'd5;
    else                   return 4'd9;
  endfunction

  // hiccup multiple of the rise time
  function automatic logic [2:0] hiccup_mult(input logic [2:0] code);
    return (code <= 3'd1) ? 3'd1 : code;
  endfunction

endpackage

// File: rtl/uvf_cfg_reg.sv
module uvf_cfg_reg
  import uvf_pkg::*;
#(
  parameter logic [7:0] RST_CFG = 8'h80
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_valid,
  input  logic [7:0] wr_data,
  input  logic    inv_clr,
  output uv_cfg_t cfg,
  output logic    invalid
);

  uv_cfg_t wr_cfg;
  logic    wr_bad;

  assign wr_cfg = uv_cfg_t'(wr_data);
  assign wr_bad = (wr_cfg.resp == RESP_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= uv_cfg_t'(RST_CFG);
      invalid <= 1'b0;
    end else begin
      if (wr_valid && !wr_bad) cfg <= wr_cfg;
      if (wr_valid && wr_bad)  invalid <= 1'b1;
      else if (inv_clr)        invalid <= 1'b0;
    end
  end

endmodule

// File: rtl/uvf_tick_timer.sv
module uvf_tick_timer #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         hit
);

  logic [W-1:0] cnt;
  logic [W:0]   nxt;

  assign nxt = {1'b0, cnt} + 1'b1;
  // a zero limit ends the interval at once
  assign hit = (lim == '0) | (en & (nxt >= {1'b0, lim}));

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= nxt[W-1:0];
  end

endmodule

// File: rtl/uvf_retry_track.sv
module uvf_retry_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       inc,
  input  logic [2:0] policy,
  output logic       may_retry
);

  import uvf_pkg::*;

  logic [2:0] used;

  assign may_retry = (policy == RETRY_FOREVER) || (used < policy);

  always_ff @(posedge clk) begin
    if (!rst_n)                   used <= '0;
    else if (clr)                 used <= '0;
    else if (inc && used != 3'd7) used <= used + 3'd1;
  end

endmodule

// File: rtl/uvf_seq.sv
module uvf_seq
  import uvf_pkg::*;
#(
  parameter int RISE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic              uv_flag,
  input  logic              pwm_tick,
  input  logic              startup_done,
  input  logic [RISE_W-1:0] rise_ticks,
  input  uv_cfg_t           cfg,
  output logic              pwr_en,
  output logic              latched_off
);

  localparam int CNT_W = RISE_W + 3;

  seq_st_e           st, st_n;
  logic              run_q, run_rise;
  logic              tmr_clr, tmr_en, tmr_hit;
  logic [CNT_W-1:0]  tmr_lim;
  logic              rty_clr, rty_inc, may_retry;
  logic              success;
  seq_st_e           shut_st;

  assign run_rise = run_req & ~run_q;
  assign success  = (st == ST_RUN) & startup_done & ~uv_flag;
  assign shut_st  = may_retry ? ST_HICCUP : ST_LATCH;

  always_comb begin
    if (st == ST_WAIT)
      tmr_lim = CNT_W'(dly_ticks(cfg.dly));
    else
      tmr_lim = CNT_W'(hiccup_mult(cfg.dly)) * CNT_W'(rise_ticks);
  end

  always_comb begin
    st_n    = st;
    rty_inc = 1'b0;
    unique case (st)
      ST_OFF:  if (run_req) st_n = ST_RUN;
      ST_RUN: begin
        if (uv_flag) begin
          if (cfg.resp == RESP_IMMED)        st_n = shut_st;
          else if (cfg.resp == RESP_DELAYED) st_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (uv_flag && cfg.resp == RESP_IMMED)        st_n = shut_st;
        else if (!uv_flag || cfg.resp != RESP_DELAYED) st_n = ST_RUN;
        else if (tmr_hit)                              st_n = shut_st;
      end
      ST_HICCUP: begin
        if (tmr_hit) begin
          st_n    = ST_RUN;
          rty_inc = 1'b1;
        end
      end
      ST_LATCH: if (run_rise) st_n = ST_RUN;
      default:  st_n = ST_OFF;
    endcase
    // OFF command overrides everything except an active latch-off
    if (!run_req && st != ST_LATCH) begin
      st_n    = ST_OFF;
      rty_inc = 1'b0;
    end
  end

  assign tmr_en  = pwm_tick & (((st == ST_WAIT) & uv_flag) | (st == ST_HICCUP));
  assign tmr_clr = (st_n != st) | ((st == ST_WAIT) & ~uv_flag);
  assign rty_clr = ~run_req | success | ((st == ST_LATCH) & run_rise);

  uvf_tick_timer #(.W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .lim   (tmr_lim),
    .hit   (tmr_hit)
  );

  uvf_retry_track u_rty (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rty_clr),
    .inc       (rty_inc),
    .policy    (cfg.retry),
    .may_retry (may_retry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_OFF;
      run_q <= 1'b0;
    end else begin
      st    <= st_n;
      run_q <= run_req;
    end
  end

  assign pwr_en      = (st == ST_RUN) | (st == ST_WAIT);
  assign latched_off = (st == ST_LATCH);

endmodule

// File: rtl/uv_fault_ctl.sv
module uv_fault_ctl
  import uvf_pkg::*;
#(
  parameter int         RISE_W  = 8,
  parameter logic [7:0] RST_CFG = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic              uv_flag,
  input  logic              pwm_tick,
  input  logic              startup_done,
  input  logic [RISE_W-1:0] rise_ticks,
  input  logic              cfg_valid,
  input  logic [7:0]        cfg_data,
  output logic              cfg_ready,
  output logic [7:0]        cfg_rd_data,
  input  logic              inv_clr,
  output logic              pwr_en,
  output logic              latched_off,
  output logic              cfg_invalid
);

  uv_cfg_t cfg;

  assign cfg_ready   = 1'b1;
  assign cfg_rd_data = cfg;

  uvf_cfg_reg #(.RST_CFG(RST_CFG)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (cfg_valid & cfg_ready),
    .wr_data  (cfg_data),
    .inv_clr  (inv_clr),
    .cfg      (cfg),
    .invalid  (cfg_invalid)
  );

  uvf_seq #(.RISE_W(RISE_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_req      (run_req),
    .uv_flag      (uv_flag),
    .pwm_tick     (pwm_tick),
    .startup_done (startup_done),
    .rise_ticks   (rise_ticks),
    .cfg          (cfg),
    .pwr_en       (pwr_en),
    .latched_off  (latched_off)
  );

endmodule

// File: rtl/uv_fault_ctl_chk.sv
module uv_fault_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_req,
  input logic       uv_flag,
  input logic       cfg_valid,
  input logic [7:0] cfg_data,
  input logic [7:0] cfg_rd_data,
  input logic       inv_clr,
  input logic       pwr_en,
  input logic       latched_off,
  input logic       cfg_invalid
);

  // R2
  off_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_req |=> !pwr_en);

  // R3
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en && run_req && cfg_rd_data[7:6] == 2'b00 |=> pwr_en);

  // R4
  immed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en && uv_flag && cfg_rd_data[7:6] == 2'b10 |=> !pwr_en);

  // R8
  latch_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en && run_req && uv_flag && cfg_rd_data[7:3] == 5'b10000 |=> latched_off);

  // R12
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_data[7:6] == 2'b11 |=> cfg_invalid && $stable(cfg_rd_data));

  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_invalid && !inv_clr && !(cfg_valid && cfg_data[7:6] == 2'b11) |=> cfg_invalid);

  // R13
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off && !(run_req && !$past(run_req)) |=> latched_off);

  // R13
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_en && latched_off));

endmodule

bind uv_fault_ctl uv_fault_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_req     (run_req),
  .uv_flag     (uv_flag),
  .cfg_valid   (cfg_valid),
  .cfg_data    (cfg_data),
  .cfg_rd_data (cfg_rd_data),
  .inv_clr     (inv_clr),
  .pwr_en      (pwr_en),
  .latched_off (latched_off),
  .cfg_invalid (cfg_invalid)
);

// File: tb/uv_fault_ctl_test.sv
`timescale 1ns/1ps
module uv_fault_ctl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_req = 1'b0;
  logic       uv_flag = 1'b0;
  logic       pwm_tick = 1'b0;
  logic       startup_done = 1'b0;
  logic [7:0] rise_ticks = 8'd3;
  logic       cfg_valid = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       cfg_ready;
  logic [7:0] cfg_rd_data;
  logic       inv_clr = 1'b0;
  logic       pwr_en, latched_off, cfg_invalid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uv_fault_ctl uut (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .uv_flag(uv_flag),
    .pwm_tick(pwm_tick), .startup_done(startup_done), .rise_ticks(rise_ticks),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_ready(cfg_ready),
    .cfg_rd_data(cfg_rd_data), .inv_clr(inv_clr), .pwr_en(pwr_en),
    .latched_off(latched_off), .cfg_invalid(cfg_invalid)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    pwm_tick = 1'b1; cyc(); pwm_tick = 1'b0;
  endtask

  task automatic wr_cfg(input logic [7:0] d);
    cfg_valid = 1'b1; cfg_data = d; cyc(); cfg_valid = 1'b0;
  endtask

  task automatic restart();
    uv_flag = 1'b0; run_req = 1'b0; cyc(); run_req = 1'b1; cyc();
  endtask

  task automatic t_reset();
    check("R1 pwr_en", pwr_en, 0);
    check("R1 latched", latched_off, 0);
    check("R1 invalid", cfg_invalid, 0);
    check("R1 readback", cfg_rd_data, 8'h80);
    check("R14 ready", cfg_ready, 1);
  endtask

  task automatic t_enable();
    run_req = 1'b1; cyc();
    check("R2 enable", pwr_en, 1);
  endtask

  task automatic t_ignore_then_fly();
    wr_cfg(8'h00);
    check("R14 readback", cfg_rd_data, 8'h00);
    uv_flag = 1'b1; cyc(); tick(); tick(); tick(); tick();
    check("R3 ignored", pwr_en, 1);
    wr_cfg(8'h80);
    check("R14 after write", cfg_rd_data, 8'h80);
    cyc();
    check("R14 new policy pwr", pwr_en, 0);
    check("R8 latched", latched_off, 1);
  endtask

  task automatic t_latch_hold();
    uv_flag = 1'b0;
    repeat (5) cyc();
    check("R13 hold high", latched_off, 1);
    run_req = 1'b0; cyc();
    check("R13 off keeps latch", latched_off, 1);
    run_req = 1'b1; cyc();
    check("R13 rise clears", latched_off, 0);
    check("R13 rise restarts", pwr_en, 1);
    uv_flag = 1'b1; cyc();
    check("R4 immediate", pwr_en, 0);
    restart();
  endtask

  task automatic t_delay(input logic [2:0] code, input int n);
    wr_cfg(8'h40 | 8'(code));
    uv_flag = 1'b1; cyc();
    for (int i = 1; i <= n; i++) begin
      tick();
      if (i < n) check("R5 before limit", pwr_en, 1);
      else       check("R5 at limit", pwr_en, 0);
    end
    check("R8 delayed latch", latched_off, 1);
    restart();
  endtask

  task automatic t_abort();
    wr_cfg(8'h42);
    uv_flag = 1'b1; cyc();
    repeat (4) tick();
    uv_flag = 1'b0; cyc();
    uv_flag = 1'b1; cyc();
    repeat (4) tick();
    check("R6 count restarted", pwr_en, 1);
    tick();
    check("R6 full count", pwr_en, 0);
    restart();
  endtask

  task automatic t_bounded_retry();
    rise_ticks = 8'd2;
    wr_cfg(8'h93);
    uv_flag = 1'b1; cyc();
    check("R9 first shutdown", pwr_en, 0);
    check("R9 not latched", latched_off, 0);
    repeat (5) tick();
    check("R7 still waiting", pwr_en, 0);
    tick();
    check("R7 attempt 1", pwr_en, 1);
    cyc();
    check("R9 second hiccup", latched_off, 0);
    check("R9 second hiccup pwr", pwr_en, 0);
    repeat (6) tick();
    check("R7 attempt 2", pwr_en, 1);
    cyc();
    check("R9 exhausted", latched_off, 1);
    restart();
  endtask

  task automatic t_forever();
    rise_ticks = 8'd3;
    wr_cfg(8'hB8);
    uv_flag = 1'b1; cyc();
    for (int k = 0; k < 10; k++) begin
      check("R10 in hiccup", latched_off, 0);
      repeat (2) tick();
      check("R7 code0 wait", pwr_en, 0);
      tick();
      check("R10 restart", pwr_en, 1);
      cyc();
    end
    run_req = 1'b0; cyc();
    check("R2 off in hiccup", pwr_en, 0);
    repeat (4) tick();
    check("R2 stays off", pwr_en, 0);
    check("R2 not latched", latched_off, 0);
    restart();
  endtask

  task automatic t_success();
    wr_cfg(8'h88);
    uv_flag = 1'b1; cyc();
    repeat (3) tick();
    check("R11 attempt", pwr_en, 1);
    uv_flag = 1'b0; startup_done = 1'b1; cyc(); startup_done = 1'b0;
    uv_flag = 1'b1; cyc();
    check("R11 count cleared", latched_off, 0);
    repeat (3) tick();
    check("R11 retry again", pwr_en, 1);
    cyc();
    check("R9 single retry used", latched_off, 1);
    restart();
  endtask

  task automatic t_invalid();
    wr_cfg(8'h48);
    wr_cfg(8'hC5);
    check("R12 flag", cfg_invalid, 1);
    check("R12 unchanged", cfg_rd_data, 8'h48);
    repeat (3) cyc();
    check("R12 sticky", cfg_invalid, 1);
    inv_clr = 1'b1; cyc(); inv_clr = 1'b0;
    check("R12 cleared", cfg_invalid, 0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1; cyc();
    t_reset();
    t_enable();
    t_ignore_then_fly();
    t_latch_hold();
    t_delay(3'd1, 3);
    t_delay(3'd4, 5);
    t_delay(3'd7, 9);
    t_abort();
    t_bounded_retry();
    t_forever();
    t_success();
    t_invalid();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule